// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Unit

This block sits between a processor pipeline and a data memory one word wide. It takes a load or store request made of a six-bit operation code, a base register value, a signed 16-bit displacement and, for stores, the source register value. From these it forms the effective address. For a store it raises the byte-lane enables and steers the source bytes into the lanes they occupy. For a load it picks the addressed byte, halfword or word out of the returned word and widens it to a full register value.

Lanes are mapped big-endian: the byte at the lowest address of a word travels in the most significant lane, and enable bit 3 belongs to byte offset 0. Halfwords must sit on even addresses and words on multiples of four. A request that breaks this is not performed. The block flags it for one cycle, and neither memory nor the register file is written.

A small sequencer drives the work through five named states:
- IDLE: ready for a request.
- WRITE: one cycle of memory write.
- READ: one cycle of memory read request.
- RETURN: the registered memory data is back and the register write happens.
- FAULT: the alignment error is reported.

The transitions are:
- IDLE→WRITE: an aligned store is accepted.
- IDLE→READ: an aligned load is accepted.
- IDLE→FAULT: a misaligned request is accepted.
- READ→RETURN: always taken.
- WRITE, RETURN and FAULT→IDLE: always taken.
- IDLE→IDLE: no valid request is present, or the operation code is not recognised.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is req_base plus req_offset sign-extended to 32 bits. mem_addr carries that address with its two low bits cleared, so a negative displacement reaches lower addresses.
- R2: A word load (code 35) puts the whole returned word on rf_wdata, and rf_we is high in the RETURN cycle.
- R3: Byte loads take the byte at offset k from bits [31-8k -: 8]. Signed byte (code 32) sign-extends it and unsigned byte (code 36) zero-extends it.
- R4: Halfword loads take offset 0 from bits [31:16] and offset 2 from bits [15:0]. Signed halfword (code 33) sign-extends and unsigned halfword (code 37) zero-extends.
- R5: A word store (code 43) drives mem_be = 4'b1111 and mem_wdata = req_store.
- R6: A byte store (code 40) at offset k raises only mem_be bit 3-k and puts req_store[7:0] in every lane, so the other three bytes of the memory word keep their contents.
- R7: A halfword store (code 41) drives mem_be = 4'b1100 at offset 0 and 4'b0011 at offset 2, with req_store[15:0] in both halves. The other half of the word is left untouched.
- R8: A halfword access at an odd address, or a word access whose address is not a multiple of four, takes the FAULT state. align_err and done are high for one cycle, and mem_we, mem_re and rf_we stay low for the whole request.
- R9: A valid request with an unrecognised operation code is not accepted. req_ready stays high, and no memory access, done or align_err follows.
- R10: A store shows mem_we and done in the cycle after acceptance. A load shows mem_re in that cycle and rf_we with done one cycle later. req_ready is low from acceptance until the request completes.
- R11: After reset the unit is in IDLE with req_ready high and mem_we, mem_re, rf_we, align_err and done all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit is idle and accepts a request |
| req_op | input | 6 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_store | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Word address to memory |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte-lane enables, bit 3 is the lowest address |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_re |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 32 | Extended load result |
| align_err | output | 1 | Misaligned request reported |
| done | output | 1 | Request finished |

## Verification
The alignment check and the store-lane write path are both decided in the same acceptance cycle. A misaligned halfword or word store therefore has a fully formed set of lane enables that must not reach the memory. The bench issues stores and loads at odd and unaligned addresses just after valid writes to the same word. In the reported cycle it requires align_err high and both write strobes low. A later word load then shows that the stored word kept every byte.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE,
        SZ_HALF,
        SZ_WORD
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_RETURN,
        ST_FAULT
    } lsu_state_e;

    localparam logic [5:0] OP_LB  = 6'd32;
    localparam logic [5:0] OP_LH  = 6'd33;
    localparam logic [5:0] OP_LW  = 6'd35;
    localparam logic [5:0] OP_LBU = 6'd36;
    localparam logic [5:0] OP_LHU = 6'd37;
    localparam logic [5:0] OP_SB  = 6'd40;
    localparam logic [5:0] OP_SH  = 6'd41;
    localparam logic [5:0] OP_SW  = 6'd43;

    typedef struct packed {
        logic      known;
        logic      store;
        logic      sext;
        acc_size_e size;
    } acc_ctl_t;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [5:0] op,
    output acc_ctl_t   ctl
);

    always_comb begin
        ctl = '{known: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_WORD};
        case (op)
            OP_LB:   begin ctl.sext = 1'b1; ctl.size = SZ_BYTE; end
            OP_LBU:  ctl.size = SZ_BYTE;
            OP_LH:   begin ctl.sext = 1'b1; ctl.size = SZ_HALF; end
            OP_LHU:  ctl.size = SZ_HALF;
            OP_LW:   ctl.size = SZ_WORD;
            OP_SB:   begin ctl.store = 1'b1; ctl.size = SZ_BYTE; end
            OP_SH:   begin ctl.store = 1'b1; ctl.size = SZ_HALF; end
            OP_SW:   ctl.store = 1'b1;
            default: ctl.known = 1'b0;
        endcase
    end

endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NLANE = XLEN / 8,
    localparam int LSB_W = $clog2(NLANE)
) (
    input  acc_size_e          size,
    input  logic [LSB_W-1:0]   off,
    input  logic [XLEN-1:0]    src,
    output logic [NLANE-1:0]   be,
    output logic [XLEN-1:0]    wdata
);

    // Byte offset j travels in lane NLANE-1-j (big-endian).
    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        localparam int LANE = NLANE - 1 - j;
        localparam logic [LSB_W-1:0] BOFF = LSB_W'(j);
        localparam logic [LSB_W-1:0] HOFF = LSB_W'((j / 2) * 2);

        always_comb begin
            unique case (size)
                SZ_WORD: begin
                    be[LANE]          = 1'b1;
                    wdata[LANE*8 +: 8] = src[LANE*8 +: 8];
                end
                SZ_HALF: begin
                    be[LANE]          = ({off[LSB_W-1:1], 1'b0} == HOFF);
                    wdata[LANE*8 +: 8] = (j % 2 == 0) ? src[15:8] : src[7:0];
                end
                default: begin
                    be[LANE]          = (off == BOFF);
                    wdata[LANE*8 +: 8] = src[7:0];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int NLANE = XLEN / 8,
    localparam int LSB_W = $clog2(NLANE)
) (
    input  acc_size_e          size,
    input  logic               sext,
    input  logic [LSB_W-1:0]   off,
    input  logic [XLEN-1:0]    rdata,
    output logic [XLEN-1:0]    value
);

    int         bpos;
    int         hpos;
    logic [7:0] bsel;
    logic [15:0] hsel;

    always_comb begin
        bpos = (NLANE - 1 - int'(off)) * 8;
        hpos = (NLANE - 2 - int'({off[LSB_W-1:1], 1'b0})) * 8;
        bsel = rdata[bpos +: 8];
        hsel = rdata[hpos +: 16];
        unique case (size)
            SZ_WORD: value = rdata;
            SZ_HALF: value = {{(XLEN-16){sext & hsel[15]}}, hsel};
            default: value = {{(XLEN-8){sext & bsel[7]}}, bsel};
        endcase
    end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int OP_W  = 6,
    localparam int NLANE = XLEN / 8,
    localparam int LSB_W = $clog2(NLANE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [OP_W-1:0]   req_op,
    input  logic [XLEN-1:0]   req_base,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [XLEN-1:0]   req_store,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [NLANE-1:0]  mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              rf_we,
    output logic [XLEN-1:0]   rf_wdata,
    output logic              align_err,
    output logic              done
);

    lsu_state_e        state_q, state_d;
    acc_ctl_t          dec;
    logic [XLEN-1:0]   ea;
    logic              misaligned;
    logic              accept;

    logic [XLEN-1:0]   ea_q;
    logic [XLEN-1:0]   data_q;
    acc_size_e         size_q;
    logic              sext_q;

    logic [NLANE-1:0]  lane_be;
    logic [XLEN-1:0]   lane_wdata;
    logic [XLEN-1:0]   load_value;

    lsu_decode u_dec (
        .op  (req_op),
        .ctl (dec)
    );

    assign ea = req_base + {{(XLEN-OFF_W){req_offset[OFF_W-1]}}, req_offset};

    always_comb begin
        unique case (dec.size)
            SZ_WORD: misaligned = |ea[LSB_W-1:0];
            SZ_HALF: misaligned = ea[0];
            default: misaligned = 1'b0;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && req_valid && dec.known;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q   <= '0;
            data_q <= '0;
            size_q <= SZ_WORD;
            sext_q <= 1'b0;
        end else if (accept) begin
            ea_q   <= ea;
            data_q <= req_store;
            size_q <= dec.size;
            sext_q <= dec.sext;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (misaligned)     state_d = ST_FAULT;
                    else if (dec.store) state_d = ST_WRITE;
                    else                state_d = ST_READ;
                end
            end
            ST_READ:   state_d = ST_RETURN;
            ST_WRITE,
            ST_RETURN,
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    lsu_store_lanes #(.XLEN(XLEN)) u_lanes (
        .size  (size_q),
        .off   (ea_q[LSB_W-1:0]),
        .src   (data_q),
        .be    (lane_be),
        .wdata (lane_wdata)
    );

    lsu_load_extract #(.XLEN(XLEN)) u_extract (
        .size  (size_q),
        .sext  (sext_q),
        .off   (ea_q[LSB_W-1:0]),
        .rdata (mem_rdata),
        .value (load_value)
    );

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_be    = '0;
        mem_wdata = lane_wdata;
        mem_addr  = {ea_q[XLEN-1:LSB_W], {LSB_W{1'b0}}};
        rf_we     = 1'b0;
        rf_wdata  = '0;
        align_err = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_WRITE: begin
                mem_we = 1'b1;
                mem_be = lane_be;
                done   = 1'b1;
            end
            ST_READ:  mem_re = 1'b1;
            ST_RETURN: begin
                rf_we    = 1'b1;
                rf_wdata = load_value;
                done     = 1'b1;
            end
            ST_FAULT: begin
                align_err = 1'b1;
                done      = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       mem_re,
    input logic       mem_we,
    input logic [3:0] mem_be,
    input logic       rf_we,
    input logic       align_err,
    input logic       done
);

    // R8: a reported fault never coincides with any write or read
    a_r8_fault_blocks_access: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!mem_we && !rf_we && !mem_re));

    // R8: the cycle after a fault carries no register write
    a_r8_fault_no_late_write: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |=> !rf_we);

    // R10: a read request is followed by the register write and completion
    a_r10_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (rf_we && done));

    // R10: a write lasts one cycle and the unit is ready again afterwards
    a_r10_write_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we && req_ready));

    // R10: completion always comes from a write, a register write or a fault
    a_r10_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_we || rf_we || align_err));

    // R10: the unit is not ready while it is signalling completion
    a_r10_busy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);

    // R6 / R7 / R5: the enables form a legal lane group
    a_r7_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 ||
                    mem_be == 4'b0011 || mem_be == 4'b1111));

    // R11: at most one of the strobes is active in any cycle
    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re, rf_we, align_err}));

endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .rf_we     (rf_we),
    .align_err (align_err),
    .done      (done)
);

// File: tb/lsu_lane_unit_test.sv
`timescale 1ns/1ps
module lsu_lane_unit_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [5:0]  req_op;
    logic [31:0] req_base;
    logic [15:0] req_offset;
    logic [31:0] req_store;
    logic [31:0] mem_addr;
    logic        mem_re;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        rf_we;
    logic [31:0] rf_wdata;
    logic        align_err;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] ram [16];

    always #2.5 clk = ~clk;

    lsu_lane_unit uut (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_base,
        .req_offset, .req_store, .mem_addr, .mem_re, .mem_we, .mem_be,
        .mem_wdata, .mem_rdata, .rf_we, .rf_wdata, .align_err, .done
    );

    // Registered memory model
    always @(posedge clk) begin
        if (mem_we)
            for (int i = 0; i < 4; i++)
                if (mem_be[i]) ram[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
        if (mem_re) mem_rdata <= ram[mem_addr[5:2]];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [5:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] sd);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_base   = base;
        req_offset = off;
        req_store  = sd;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "req_ready", 32'(req_ready), 32'd1);
        chk("R11", "strobes", {27'd0, mem_we, mem_re, rf_we, align_err, done}, 32'd0);
    endtask

    task automatic t_store(input string req, input logic [5:0] op,
                           input logic [31:0] base, input logic [15:0] off,
                           input logic [31:0] sd, input logic [3:0] exp_be,
                           input logic [31:0] exp_wd, input logic [31:0] exp_addr);
        issue(op, base, off, sd);
        chk(req,   "mem_we",    32'(mem_we), 32'd1);
        chk(req,   "mem_be",    32'(mem_be), 32'(exp_be));
        chk(req,   "mem_wdata", mem_wdata, exp_wd);
        chk("R1",  "mem_addr",  mem_addr, exp_addr);
        chk("R10", "store done/ready", {30'd0, done, req_ready}, 32'd2);
    endtask

    task automatic t_load(input string req, input logic [5:0] op,
                          input logic [31:0] base, input logic [15:0] off,
                          input logic [31:0] exp_val, input logic [31:0] exp_addr);
        issue(op, base, off, 32'h0);
        chk("R10", "read cycle re/done/rf_we", {29'd0, mem_re, done, rf_we}, 32'd4);
        chk("R1",  "mem_addr", mem_addr, exp_addr);
        @(negedge clk);
        chk("R10", "return rf_we/done", {30'd0, rf_we, done}, 32'd3);
        chk(req,   "rf_wdata", rf_wdata, exp_val);
    endtask

    task automatic t_fault(input logic [5:0] op, input logic [31:0] base,
                           input logic [15:0] off, input logic [31:0] sd);
        issue(op, base, off, sd);
        chk("R8", "align_err/done", {30'd0, align_err, done}, 32'd3);
        chk("R8", "we/re/rf_we in fault", {29'd0, mem_we, mem_re, rf_we}, 32'd0);
        @(negedge clk);
        chk("R8", "after fault we/re/rf_we", {29'd0, mem_we, mem_re, rf_we}, 32'd0);
        chk("R8", "ready after fault", 32'(req_ready), 32'd1);
    endtask

    task automatic t_unknown();
        issue(6'd0, 32'h18, 16'h0, 32'hFFFF_FFFF);
        chk("R9", "ready held", 32'(req_ready), 32'd1);
        chk("R9", "no activity", {27'd0, mem_we, mem_re, rf_we, align_err, done}, 32'd0);
        @(negedge clk);
        chk("R9", "no activity later", {27'd0, mem_we, mem_re, rf_we, align_err, done}, 32'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_op = '0; req_base = '0; req_offset = '0; req_store = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        // R5 word store, R2 word load, R1 negative displacement
        t_store("R5", 6'd43, 32'h10, 16'h0004, 32'hDEADBEEF, 4'hF, 32'hDEADBEEF, 32'h14);
        t_load ("R2", 6'd35, 32'h10, 16'h0004, 32'hDEADBEEF, 32'h14);
        t_load ("R1", 6'd35, 32'h20, 16'hFFF4, 32'hDEADBEEF, 32'h14);

        // R6 byte store into a known word
        t_store("R5", 6'd43, 32'h18, 16'h0000, 32'h11223344, 4'hF, 32'h11223344, 32'h18);
        t_store("R6", 6'd40, 32'h18, 16'h0001, 32'hAAAAAA5A, 4'b0100, 32'h5A5A5A5A, 32'h18);
        t_load ("R6", 6'd35, 32'h18, 16'h0000, 32'h115A3344, 32'h18);

        // R3 byte loads
        t_load ("R3", 6'd32, 32'h14, 16'h0000, 32'hFFFFFFDE, 32'h14);
        t_load ("R3", 6'd36, 32'h14, 16'h0000, 32'h000000DE, 32'h14);
        t_load ("R3", 6'd32, 32'h18, 16'h0001, 32'h0000005A, 32'h18);
        t_load ("R3", 6'd32, 32'h14, 16'h0003, 32'hFFFFFFEF, 32'h14);

        // R7 halfword store at offset 2, negative displacement
        t_store("R7", 6'd41, 32'h1C, 16'hFFFE, 32'h1234ABCD, 4'b0011, 32'hABCDABCD, 32'h18);
        t_load ("R7", 6'd35, 32'h18, 16'h0000, 32'h115AABCD, 32'h18);

        // R4 halfword loads
        t_load ("R4", 6'd33, 32'h14, 16'h0000, 32'hFFFFDEAD, 32'h14);
        t_load ("R4", 6'd37, 32'h14, 16'h0002, 32'h0000BEEF, 32'h14);
        t_load ("R4", 6'd33, 32'h14, 16'h0002, 32'hFFFFBEEF, 32'h14);
        t_load ("R4", 6'd33, 32'h18, 16'h0000, 32'h0000115A, 32'h18);

        // R8 misaligned accesses leave memory and registers alone
        t_fault(6'd41, 32'h18, 16'h0001, 32'h00000000);
        t_load ("R8", 6'd35, 32'h18, 16'h0000, 32'h115AABCD, 32'h18);
        t_fault(6'd35, 32'h14, 16'h0002, 32'h0);
        t_fault(6'd43, 32'h18, 16'h0003, 32'h00000000);
        t_fault(6'd33, 32'h14, 16'h0001, 32'h0);
        t_load ("R8", 6'd35, 32'h18, 16'h0000, 32'h115AABCD, 32'h18);

        // R9 unrecognised code
        t_unknown();
        t_load ("R9", 6'd35, 32'h18, 16'h0000, 32'h115AABCD, 32'h18);

        summary();
        $finish;
    end

endmodule